// File: doc/BRIEF.md
# Four-Channel Pin Edge Capture

This block timestamps transitions on general-purpose pins. Each of four channels picks one line out of a 32-bit pin vector using a small select code. The picked line is brought into the clock domain by two flops, and an edge register then compares it with its value one cycle earlier. When the transition matches the polarity chosen for that channel, the channel copies the free-running 24-bit timer value it is given into its own capture register and raises a sticky pending flag.

The pending flag holds its capture register frozen, so the first event is kept until software acknowledges it. Software acknowledges an event by pulsing that channel's clear strobe. Each pending flag is masked by an enable bit for its channel, and the masked flags are combined into one interrupt line. The synchronized level of every channel's pin is also brought out so that software can poll it. The timer and the register decode are outside this block.

Top module: `pin_capture_unit`

## Requirements
- R1: Select code k in 1..32 routes pin bit k-1 of `gpio_in` to the channel. Channel i's code sits in `sel_code[6*i+5:6*i]`.
- R2: A select code of 0, or any code above 32, turns the channel off. The channel then reports level 0 and never captures, whatever the pins do.
- R3: Bit i of `fall_sel` picks the polarity for channel i: 1 captures on a falling edge, 0 on a rising edge. The opposite edge has no effect.
- R4: A qualifying edge loads `tmr_val`, as sampled at the third rising clock edge after the pin change, into `cap_val[24*i+23:24*i]`. The pending flag rises at that same clock edge.
- R5: A pending flag stays set until its clear strobe is asserted.
- R6: A one-cycle pulse on `clr_pend[i]` clears pending flag i. If a qualifying edge falls in the same cycle as the clear, the edge wins: the flag stays set and the new timer value is captured.
- R7: While pending flag i is set and no clear is applied, further edges leave `cap_val` for channel i unchanged.
- R8: `cap_irq` is high exactly when some channel has its pending flag set and its bit in `irq_en` set.
- R9: `pin_lvl[i]` shows the level of the selected pin two clock edges after it changes.
- R10: After reset, all pending flags, capture registers, levels and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 32 | Raw pin vector |
| tmr_val | input | 24 | Current timer count |
| sel_code | input | 24 | Four 6-bit pin select codes, channel 0 in the low bits |
| fall_sel | input | 4 | Per-channel polarity, 1 = falling |
| irq_en | input | 4 | Per-channel interrupt enable |
| clr_pend | input | 4 | Per-channel pending clear strobe |
| cap_val | output | 96 | Four 24-bit captured timer values |
| pend | output | 4 | Sticky pending flags |
| pin_lvl | output | 4 | Synchronized selected pin levels |
| cap_irq | output | 1 | Combined capture interrupt |

## Verification
A corrupted synchronizer or edge register shows up as a pending flag that rises one cycle early or one cycle late. It can also show up as a flag raised by the wrong polarity, which is visible within three clocks of the pin change. A wrong pending state shows up directly on `pend` and `cap_irq` in the same cycle. It also shows up later as a capture register that gets overwritten by a second edge, or that misses the next event after a clear. Mis-routing by the select code appears as captures from pins that should be ignored, or as a level stuck at 0.

// File: rtl/pin_capture_unit.sv
module pin_capture_unit #(
  parameter int NCH  = 4,
  parameter int NPIN = 32,
  parameter int TW   = 24,
  parameter int SELW = $clog2(NPIN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIN-1:0]     gpio_in,
  input  logic [TW-1:0]       tmr_val,
  input  logic [NCH*SELW-1:0] sel_code,
  input  logic [NCH-1:0]      fall_sel,
  input  logic [NCH-1:0]      irq_en,
  input  logic [NCH-1:0]      clr_pend,
  output logic [NCH*TW-1:0]   cap_val,
  output logic [NCH-1:0]      pend,
  output logic [NCH-1:0]      pin_lvl,
  output logic                cap_irq
);

  logic [NCH-1:0] raw, live, s1, s2, prv, hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SELW-1:0] code;
    logic [TW-1:0]   cap_q;
    assign code = sel_code[i*SELW +: SELW];

    always_comb begin
      raw[i]  = 1'b0;
      live[i] = 1'b0;
      for (int j = 0; j < NPIN; j++) begin
        if (code == SELW'(j + 1)) begin
          raw[i]  = gpio_in[j];
          live[i] = 1'b1;
        end
      end
    end

    assign hit[i] = live[i] & (fall_sel[i] ? (prv[i] & ~s2[i]) : (s2[i] & ~prv[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i]   <= 1'b0;
        s2[i]   <= 1'b0;
        prv[i]  <= 1'b0;
        pend[i] <= 1'b0;
        cap_q   <= '0;
      end else begin
        s1[i]  <= raw[i];
        s2[i]  <= s1[i];
        prv[i] <= s2[i];
        if (hit[i] && (!pend[i] || clr_pend[i])) begin
          cap_q   <= tmr_val;
          pend[i] <= 1'b1;
        end else if (clr_pend[i]) begin
          pend[i] <= 1'b0;
        end
      end
    end

    assign cap_val[i*TW +: TW] = cap_q;
  end

  assign pin_lvl = s2;
  assign cap_irq = |(pend & irq_en);

endmodule

module pin_capture_props #(
  parameter int NCH  = 4,
  parameter int TW   = 24,
  parameter int SELW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [TW-1:0]       tmr_val,
  input logic [NCH*SELW-1:0] sel_code,
  input logic [NCH-1:0]      irq_en,
  input logic [NCH-1:0]      clr_pend,
  input logic [NCH*TW-1:0]   cap_val,
  input logic [NCH-1:0]      pend,
  input logic                cap_irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] && !clr_pend[i] |=> pend[i]);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] && !clr_pend[i] |=> $stable(cap_val[i*TW +: TW]));
    p_grab_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> cap_val[i*TW +: TW] == $past(tmr_val));
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) && irq_en[i] |-> cap_irq);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend[i] && sel_code[i*SELW +: SELW] == '0 |=> !pend[i]);
  end
endmodule

bind pin_capture_unit pin_capture_props #(.NCH(NCH), .TW(TW), .SELW(SELW)) u_props (
  .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .sel_code(sel_code),
  .irq_en(irq_en), .clr_pend(clr_pend), .cap_val(cap_val), .pend(pend),
  .cap_irq(cap_irq)
);

// File: tb/sim_pin_capture_unit.sv
module sim_pin_capture_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gpio_in = '0;
  logic [23:0] tmr_val = '0;
  logic [23:0] sel_code;
  logic [3:0]  fall_sel, irq_en, clr_pend;
  logic [95:0] cap_val;
  logic [3:0]  pend, pin_lvl;
  logic        cap_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_capture_unit u0 (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .tmr_val(tmr_val),
    .sel_code(sel_code), .fall_sel(fall_sel), .irq_en(irq_en),
    .clr_pend(clr_pend), .cap_val(cap_val), .pend(pend),
    .pin_lvl(pin_lvl), .cap_irq(cap_irq)
  );

  typedef struct {
    int          kind;
    int          ch;
    logic [23:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic expect_item(int kind, int ch, logic [23:0] val, string tag);
    exp_t e;
    e.kind = kind; e.ch = ch; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [23:0] act;
      e = q.pop_front();
      case (e.kind)
        0: act = cap_val[e.ch*24 +: 24];
        1: act = {20'd0, pend};
        2: act = {20'd0, pin_lvl};
        default: act = {23'd0, cap_irq};
      endcase
      compared++;
      if (act !== e.val) begin
        mismatched++;
        $display("FAIL %s kind=%0d ch=%0d actual=%h expected=%h", e.tag, e.kind, e.ch, act, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    sel_code = {6'd33, 6'd0, 6'd32, 6'd1};
    fall_sel = 4'b0010;
    irq_en   = 4'b0000;
    clr_pend = 4'b0000;
    step(3);
    rst_n = 1'b1;
    step();
    // R10 reset state
    expect_item(1, 0, 24'h0, "R10");
    expect_item(2, 0, 24'h0, "R10");
    expect_item(3, 0, 24'h0, "R10");
    for (int c = 0; c < 4; c++) expect_item(0, c, 24'h0, "R10");
    step();

    // R1 R4 R9: channel 0 rising on pin 0, latency
    tmr_val = 24'h123456;
    gpio_in[0] = 1'b1;
    step();
    expect_item(1, 0, 24'h0, "R4 not before third edge");
    expect_item(2, 0, 24'h1, "R9");
    step();
    expect_item(1, 0, 24'h1, "R4");
    expect_item(0, 0, 24'h123456, "R1 R4");
    step(2);

    // R3: channel 1 falling on pin 31
    tmr_val = 24'h00AAAA;
    gpio_in[31] = 1'b1;
    step(4);
    expect_item(1, 0, 24'h1, "R3 rise ignored");
    step();
    tmr_val = 24'h00BBBB;
    gpio_in[31] = 1'b0;
    step(4);
    expect_item(1, 0, 24'h3, "R3 fall");
    expect_item(0, 1, 24'h00BBBB, "R3");
    step();

    // R7: no overwrite while pending
    tmr_val = 24'h000777;
    gpio_in[0] = 1'b0;
    step(4);
    gpio_in[0] = 1'b1;
    step(4);
    expect_item(0, 0, 24'h123456, "R7");
    expect_item(1, 0, 24'h3, "R5");
    step();

    // R8: interrupt masking
    expect_item(3, 0, 24'h0, "R8 all masked");
    step();
    irq_en = 4'b0100;
    expect_item(3, 0, 24'h0, "R8 enabled channel idle");
    step();
    irq_en = 4'b0010;
    expect_item(3, 0, 24'h1, "R8");
    step();

    // R6: clear channel 1
    clr_pend = 4'b0010;
    step();
    clr_pend = 4'b0000;
    expect_item(1, 0, 24'h1, "R6");
    expect_item(3, 0, 24'h0, "R6 R8");
    step();

    // R6: clear coinciding with an edge on channel 0
    gpio_in[0] = 1'b0;
    step(4);
    tmr_val = 24'h00C0DE;
    gpio_in[0] = 1'b1;
    step(2);
    clr_pend = 4'b0001;
    step();
    clr_pend = 4'b0000;
    expect_item(1, 0, 24'h1, "R6 edge wins");
    expect_item(0, 0, 24'h00C0DE, "R6 edge wins");
    step();

    // R2: disabled channels ignore all pins
    tmr_val = 24'h0F0F0F;
    gpio_in[30:1] = '1;
    step(4);
    expect_item(2, 0, 24'h1, "R2 level");
    step();
    gpio_in[30:1] = '0;
    step(4);
    expect_item(1, 0, 24'h1, "R2");
    expect_item(0, 2, 24'h0, "R2");
    expect_item(0, 3, 24'h0, "R2");
    step();

    // R1: channel 3 routed to pin 16
    sel_code[23:18] = 6'd17;
    step();
    tmr_val = 24'h000316;
    gpio_in[16] = 1'b1;
    step(4);
    expect_item(1, 0, 24'h9, "R1");
    expect_item(0, 3, 24'h000316, "R1");
    expect_item(2, 0, 24'h9, "R1 R9");
    step();

    // R6: after clear, a new edge captures again
    clr_pend = 4'b0001;
    step();
    clr_pend = 4'b0000;
    gpio_in[0] = 1'b0;
    step(4);
    expect_item(1, 0, 24'h8, "R6 cleared");
    step();
    tmr_val = 24'h000ABC;
    gpio_in[0] = 1'b1;
    step(4);
    expect_item(0, 0, 24'h000ABC, "R6 recapture");
    expect_item(1, 0, 24'h9, "R6 recapture");
    step(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule